// File: doc/BRIEF.md
# Interrupt Controller Command Word Interface

This block is the byte-wide, two-address register front end of a classic eight-line programmable interrupt controller. A host writes bytes to address 0 or address 1. Bits inside each byte written to address 0 pick one of three command classes: an initialization start, a priority/end-of-interrupt command, or a read-control word. Address 1 writes feed the rest of the initialization sequence and, once it is over, load the interrupt mask. The block holds the configuration fields and emits one-cycle command strobes for a separate priority core. It also selects the byte returned on a read: the mask, the core's request or in-service register, or a poll answer.

An initialization sequencer with four states shares address 1 with the mask. `SEQ_RUN` is the operating state, where address 1 writes load the mask. A start word in any state moves to `SEQ_BASE`. The next address 1 write moves `SEQ_BASE` to `SEQ_CASC`. The following one leaves `SEQ_CASC` for `SEQ_MODE` if the start word asked for a mode word, or for `SEQ_RUN` if it did not. One more address 1 write moves `SEQ_MODE` to `SEQ_RUN`. Single mode and level-triggered inputs are not supported. A start word that asks for either one raises an error flag.

Top module: `picw_top`

## Requirements
- R1: After reset the sequencer is in `SEQ_RUN`, and every configuration output, strobe and the error flag are 0. A read of address 1 returns 0, and a read of address 0 returns `req_bits`.
- R2: A write to address 0 with bit 4 set is a start word. From any state it moves to `SEQ_BASE` and clears the mask, vector base, nested mode, automatic end-of-interrupt, rotate-on-automatic-end, special mask, read select and any pending poll. It pulses `init_clr` for the one cycle after the write, and it records bit 0 as "mode word follows".
- R3: A start word with bit 1 (single mode) or bit 3 (level-triggered) set sets `cfg_error`. A start word with both bits clear clears it.
- R4: In `SEQ_BASE`, an address 1 write sets `vec_base` to data bits 7:3 and moves to `SEQ_CASC`.
- R5: In `SEQ_CASC`, an address 1 write changes no output. It moves to `SEQ_MODE` if a mode word was requested, and to `SEQ_RUN` if not. Address 1 writes during initialization never change the mask.
- R6: In `SEQ_MODE`, an address 1 write sets `nested_mode` from bit 4 and `auto_eoi` from bit 1, and then moves to `SEQ_RUN`.
- R7: In `SEQ_RUN`, an address 1 write loads the mask. A read of address 1 returns the mask. The mask holds its value in every cycle without a write.
- R8: A write to address 0 with bits 4 and 3 clear is a priority command with code = bits 7:5 and line = bits 2:0. Codes 1, 3, 5, 6 and 7 pulse `cmd_vld` for the one cycle after the write, with `cmd_op` equal to the code and `cmd_line` equal to the line. Code 2 produces no strobe.
- R9: Priority codes 0 and 4 set `rotate_aeoi` from bit 7 (code 4 sets it, code 0 clears it) and produce no strobe.
- R10: A write to address 0 with bit 4 clear and bit 3 set is a read-control word. If bit 1 is set, bit 0 becomes the read select (1 gives `svc_bits`, 0 gives `req_bits` on address 0 reads). If bit 6 is set, bit 5 becomes `special_mask`. If bit 1 or bit 6 is clear, the matching field is kept.
- R11: Bit 2 of a read-control word arms a poll. The next address 0 read returns 0x80 plus `poll_line` when `poll_hit` is 1, or 0x00 when it is 0. That read asserts `poll_ack` in the same cycle and ends the poll, so the following read is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| req_bits | input | 8 | Request register from the priority core |
| svc_bits | input | 8 | In-service register from the priority core |
| poll_hit | input | 1 | Core has a line to report to a poll |
| poll_line | input | 3 | Line the core reports to a poll |
| poll_ack | output | 1 | A poll answer is being read this cycle |
| init_clr | output | 1 | One-cycle pulse: core clears its state |
| cmd_vld | output | 1 | One-cycle priority command strobe |
| cmd_op | output | 3 | Priority command code |
| cmd_line | output | 3 | Line number of the priority command |
| mask_bits | output | 8 | Interrupt mask |
| vec_base | output | 5 | Vector base (upper five bits) |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| rotate_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| cfg_error | output | 1 | An unsupported mode was requested |

## Verification
The assertions cover relations that must hold in every cycle. A clear pulse must find the mask, vector base and mode bits already cleared. The mask must stay put in any cycle without a write. A command strobe must never carry code 0, 2 or 4. Reading a poll answer must end the poll, and `SEQ_MODE` may only be entered when a mode word was requested. Ordering effects can only be seen in the bench's scenarios. These are: the sequence with and without the mode word, restarting from inside initialization, address 1 writes that must not reach the mask, the gating bits of the read-control word, and the single-read lifetime of a poll.

// File: rtl/picw_pkg.sv
package picw_pkg;
    localparam int BYTE_W = 8;
    localparam int LINE_W = $clog2(BYTE_W);
    localparam int BASE_W = BYTE_W - LINE_W;

    // Bit positions that select command classes and fields
    localparam int B_START   = 4;
    localparam int B_RCTL    = 3;
    localparam int B_NEED4   = 0;
    localparam int B_SINGLE  = 1;
    localparam int B_LEVEL   = 3;
    localparam int B_NESTED  = 4;
    localparam int B_AEOI    = 1;
    localparam int B_POLL    = 2;
    localparam int B_RSEL_EN = 1;
    localparam int B_RSEL    = 0;
    localparam int B_SMM_EN  = 6;
    localparam int B_SMM     = 5;

    typedef enum logic [1:0] {
        SEQ_RUN  = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_ROT_CLR  = 3'd0,
        OP_EOI_NS   = 3'd1,
        OP_NOP      = 3'd2,
        OP_EOI_SP   = 3'd3,
        OP_ROT_SET  = 3'd4,
        OP_ROT_NS   = 3'd5,
        OP_SET_PRIO = 3'd6,
        OP_ROT_SP   = 3'd7
    } prio_op_e;
endpackage

// File: rtl/picw_init_seq.sv
module picw_init_seq
    import picw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              tail_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              run,
    output logic              init_clr,
    output logic [BASE_W-1:0] vec_base,
    output logic              nested_mode,
    output logic              auto_eoi,
    output logic              cfg_error
);
    seq_state_e cur_q, nxt;
    logic       need4_q;
    logic       unused_bits;

    assign unused_bits = wdata[2];
    assign run         = (cur_q == SEQ_RUN);

    always_comb begin
        nxt = cur_q;
        if (start_wr) begin
            nxt = SEQ_BASE;
        end else if (tail_wr) begin
            unique case (cur_q)
                SEQ_RUN:  nxt = SEQ_RUN;
                SEQ_BASE: nxt = SEQ_CASC;
                SEQ_CASC: nxt = need4_q ? SEQ_MODE : SEQ_RUN;
                SEQ_MODE: nxt = SEQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= SEQ_RUN;
        else        cur_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_clr    <= 1'b0;
            need4_q     <= 1'b0;
            cfg_error   <= 1'b0;
            vec_base    <= '0;
            nested_mode <= 1'b0;
            auto_eoi    <= 1'b0;
        end else begin
            init_clr <= start_wr;
            if (start_wr) begin
                need4_q     <= wdata[B_NEED4];
                cfg_error   <= wdata[B_SINGLE] | wdata[B_LEVEL];
                vec_base    <= '0;
                nested_mode <= 1'b0;
                auto_eoi    <= 1'b0;
            end else if (tail_wr) begin
                unique case (cur_q)
                    SEQ_BASE: vec_base <= wdata[BYTE_W-1:LINE_W];
                    SEQ_MODE: begin
                        nested_mode <= wdata[B_NESTED];
                        auto_eoi    <= wdata[B_AEOI];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: the mode-word state is only reachable when a mode word was requested
    a_r6_mode_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == SEQ_MODE) |-> need4_q);
endmodule

// File: rtl/picw_cmd_dec.sv
module picw_cmd_dec
    import picw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              run,
    input  logic              poll_take,
    output logic              start_wr,
    output logic              tail_wr,
    output logic [BYTE_W-1:0] mask_bits,
    output logic              rd_svc,
    output logic              special_mask,
    output logic              rotate_aeoi,
    output logic              poll_pend,
    output logic              cmd_vld,
    output logic [2:0]        cmd_op,
    output logic [LINE_W-1:0] cmd_line
);
    logic     rctl_wr, prio_wr, poll_arm;
    prio_op_e code;

    assign code     = prio_op_e'(wdata[BYTE_W-1:BYTE_W-3]);
    assign start_wr = wr_en && !addr && wdata[B_START];
    assign rctl_wr  = wr_en && !addr && !wdata[B_START] && wdata[B_RCTL];
    assign prio_wr  = wr_en && !addr && !wdata[B_START] && !wdata[B_RCTL];
    assign tail_wr  = wr_en && addr;
    assign poll_arm = rctl_wr && wdata[B_POLL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_bits    <= '0;
            rd_svc       <= 1'b0;
            special_mask <= 1'b0;
            rotate_aeoi  <= 1'b0;
            poll_pend    <= 1'b0;
            cmd_vld      <= 1'b0;
            cmd_op       <= '0;
            cmd_line     <= '0;
        end else begin
            cmd_vld <= 1'b0;
            if (start_wr) begin
                mask_bits    <= '0;
                rd_svc       <= 1'b0;
                special_mask <= 1'b0;
                rotate_aeoi  <= 1'b0;
                poll_pend    <= 1'b0;
            end else begin
                if (tail_wr && run) mask_bits <= wdata;
                if (rctl_wr && wdata[B_RSEL_EN]) rd_svc <= wdata[B_RSEL];
                if (rctl_wr && wdata[B_SMM_EN]) special_mask <= wdata[B_SMM];
                if (poll_arm)       poll_pend <= 1'b1;
                else if (poll_take) poll_pend <= 1'b0;
                if (prio_wr) begin
                    unique case (code)
                        OP_ROT_CLR, OP_ROT_SET: rotate_aeoi <= wdata[BYTE_W-1];
                        OP_NOP: ;
                        default: begin
                            cmd_vld  <= 1'b1;
                            cmd_op   <= code;
                            cmd_line <= wdata[LINE_W-1:0];
                        end
                    endcase
                end
            end
        end
    end

    // R7: the mask only moves on a write
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_bits));
    // R8: rotate-setting codes and the no-op never reach the core
    a_r8_op_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> (cmd_op != 3'd0 && cmd_op != 3'd2 && cmd_op != 3'd4));
    // R11: reading a poll answer ends the poll unless it is re-armed at once
    a_r11_poll_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_take && !poll_arm && !start_wr) |=> !poll_pend);
endmodule

// File: rtl/picw_rd_mux.sv
module picw_rd_mux
    import picw_pkg::*;
(
    input  logic              rd_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] mask_bits,
    input  logic [BYTE_W-1:0] req_bits,
    input  logic [BYTE_W-1:0] svc_bits,
    input  logic              rd_svc,
    input  logic              poll_pend,
    input  logic              poll_hit,
    input  logic [LINE_W-1:0] poll_line,
    output logic              poll_take,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] poll_byte;

    assign poll_byte = poll_hit ? {1'b1, {(BYTE_W-1-LINE_W){1'b0}}, poll_line} : '0;
    assign poll_take = rd_en && !addr && poll_pend;

    always_comb begin
        if (addr)           rdata = mask_bits;
        else if (poll_pend) rdata = poll_byte;
        else if (rd_svc)    rdata = svc_bits;
        else                rdata = req_bits;
    end
endmodule

// File: rtl/picw_top.sv
module picw_top
    import picw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [BYTE_W-1:0] req_bits,
    input  logic [BYTE_W-1:0] svc_bits,
    input  logic              poll_hit,
    input  logic [LINE_W-1:0] poll_line,
    output logic              poll_ack,
    output logic              init_clr,
    output logic              cmd_vld,
    output logic [2:0]        cmd_op,
    output logic [LINE_W-1:0] cmd_line,
    output logic [BYTE_W-1:0] mask_bits,
    output logic [BASE_W-1:0] vec_base,
    output logic              nested_mode,
    output logic              auto_eoi,
    output logic              rotate_aeoi,
    output logic              special_mask,
    output logic              cfg_error
);
    logic start_wr, tail_wr, run, rd_svc, poll_pend;

    picw_cmd_dec u_dec (
        .clk, .rst_n, .wr_en, .addr, .wdata, .run,
        .poll_take(poll_ack), .start_wr, .tail_wr, .mask_bits, .rd_svc,
        .special_mask, .rotate_aeoi, .poll_pend, .cmd_vld, .cmd_op, .cmd_line
    );

    picw_init_seq u_seq (
        .clk, .rst_n, .start_wr, .tail_wr, .wdata, .run, .init_clr,
        .vec_base, .nested_mode, .auto_eoi, .cfg_error
    );

    picw_rd_mux u_mux (
        .rd_en, .addr, .mask_bits, .req_bits, .svc_bits, .rd_svc, .poll_pend,
        .poll_hit, .poll_line, .poll_take(poll_ack), .rdata
    );

    // R2: when the core is told to clear, the interface fields are already clear
    a_r2_clear_seen: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |-> (mask_bits == '0 && vec_base == '0 && !nested_mode &&
                      !auto_eoi && !rotate_aeoi && !special_mask));
endmodule

// File: tb/picw_top_test.sv
module picw_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] req_bits = 8'hA5, svc_bits = 8'h3C;
    logic       poll_hit = 1'b0;
    logic [2:0] poll_line = '0;
    logic [7:0] rdata, mask_bits;
    logic       poll_ack, init_clr, cmd_vld;
    logic [2:0] cmd_op, cmd_line;
    logic [4:0] vec_base;
    logic       nested_mode, auto_eoi, rotate_aeoi, special_mask, cfg_error;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    picw_top uut (
        .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .req_bits,
        .svc_bits, .poll_hit, .poll_line, .poll_ack, .init_clr, .cmd_vld,
        .cmd_op, .cmd_line, .mask_bits, .vec_base, .nested_mode, .auto_eoi,
        .rotate_aeoi, .special_mask, .cfg_error
    );

    typedef struct packed {
        logic       wa;
        logic [7:0] wd;
        logic       ra;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // write one byte, then read one address; req is the requirement number
    localparam vec_t VECS [10] = '{
        '{1'b1, 8'h5A, 1'b1, 8'h5A, 4'd7},
        '{1'b0, 8'h0B, 1'b0, 8'h3C, 4'd10},
        '{1'b0, 8'h0A, 1'b0, 8'hA5, 4'd10},
        '{1'b0, 8'h09, 1'b0, 8'hA5, 4'd10},
        '{1'b0, 8'h0B, 1'b0, 8'h3C, 4'd10},
        '{1'b0, 8'h08, 1'b0, 8'h3C, 4'd10},
        '{1'b1, 8'h00, 1'b1, 8'h00, 4'd7},
        '{1'b1, 8'hFF, 1'b1, 8'hFF, 4'd7},
        '{1'b0, 8'h20, 1'b1, 8'hFF, 4'd7},
        '{1'b0, 8'h0A, 1'b0, 8'hA5, 4'd10}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v, output logic ack);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        v = rdata; ack = poll_ack;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       ack;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 outputs", {init_clr, cmd_vld, nested_mode, auto_eoi, rotate_aeoi,
                           special_mask, cfg_error, poll_ack, vec_base}, 0);
        rst_n = 1'b1;
        rd(1'b1, v, ack); chk("R1 mask read", v, 8'h00);
        rd(1'b0, v, ack); chk("R1 request read", v, 8'hA5);

        // R7, R10: table walk
        foreach (VECS[i]) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd(VECS[i].ra, v, ack);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
        end

        // R2, R4, R5, R6: full sequence with mode word
        wr(1'b0, 8'h11);
        chk("R2 clear pulse", init_clr, 1'b1);
        chk("R3 no error", cfg_error, 1'b0);
        rd(1'b1, v, ack); chk("R2 mask cleared", v, 8'h00);
        chk("R2 pulse single", init_clr, 1'b0);
        wr(1'b1, 8'h47);
        chk("R4 base", vec_base, 5'h08);
        rd(1'b1, v, ack); chk("R5 mask untouched by base word", v, 8'h00);
        wr(1'b1, 8'h04);
        rd(1'b1, v, ack); chk("R5 mask untouched by cascade word", v, 8'h00);
        wr(1'b1, 8'h12);
        chk("R6 nested", nested_mode, 1'b1);
        chk("R6 auto eoi", auto_eoi, 1'b1);
        rd(1'b1, v, ack); chk("R5 mask untouched by mode word", v, 8'h00);
        wr(1'b1, 8'h33);
        rd(1'b1, v, ack); chk("R7 mask after sequence", v, 8'h33);

        // R5: sequence without mode word; R2 clears mode bits
        wr(1'b0, 8'h10);
        chk("R2 nested cleared", {nested_mode, auto_eoi}, 2'b00);
        wr(1'b1, 8'hF8);
        chk("R4 base max", vec_base, 5'h1F);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h77);
        rd(1'b1, v, ack); chk("R5 short sequence ends in run", v, 8'h77);
        chk("R5 no mode word taken", {nested_mode, auto_eoi}, 2'b00);

        // R3: unsupported modes; restart from inside initialization
        wr(1'b0, 8'h12); chk("R3 single mode", cfg_error, 1'b1);
        wr(1'b1, 8'h08);
        wr(1'b0, 8'h18); chk("R3 level mode", cfg_error, 1'b1);
        chk("R2 restart clears base", vec_base, 5'h00);
        wr(1'b0, 8'h10); chk("R3 cleared", cfg_error, 1'b0);
        wr(1'b1, 8'h00); wr(1'b1, 8'h00); wr(1'b1, 8'h3C);
        rd(1'b1, v, ack); chk("R7 mask after restart", v, 8'h3C);

        // R8: strobing priority commands
        foreach (VECS[i]) begin
            if (i < 5) begin
                logic [2:0] code;
                code = (i == 0) ? 3'd1 : (i == 1) ? 3'd3 : (i == 2) ? 3'd5 :
                       (i == 3) ? 3'd6 : 3'd7;
                wr(1'b0, {code, 2'b00, 3'(i + 2)});
                chk($sformatf("R8 code %0d", code), {cmd_vld, cmd_op, cmd_line},
                    {1'b1, code, 3'(i + 2)});
            end
        end
        wr(1'b0, 8'h45);
        chk("R8 code 2 silent", cmd_vld, 1'b0);

        // R9: rotate-on-automatic-end control
        wr(1'b0, 8'h80);
        chk("R9 rotate set", {rotate_aeoi, cmd_vld}, 2'b10);
        wr(1'b0, 8'h00);
        chk("R9 rotate clear", {rotate_aeoi, cmd_vld}, 2'b00);

        // R10: special mask gating
        wr(1'b0, 8'h68); chk("R10 special mask on", special_mask, 1'b1);
        wr(1'b0, 8'h08); chk("R10 special mask kept", special_mask, 1'b1);
        wr(1'b0, 8'h48); chk("R10 special mask off", special_mask, 1'b0);

        // R11: poll with and without a pending line
        poll_hit = 1'b1; poll_line = 3'd5;
        wr(1'b0, 8'h0C);
        rd(1'b1, v, ack); chk("R11 address 1 read keeps poll", {ack, v}, {1'b0, 8'h3C});
        rd(1'b0, v, ack); chk("R11 poll hit", {ack, v}, {1'b1, 8'h85});
        rd(1'b0, v, ack); chk("R11 poll ended", {ack, v}, {1'b0, 8'hA5});
        poll_hit = 1'b0;
        wr(1'b0, 8'h0C);
        rd(1'b0, v, ack); chk("R11 poll empty", {ack, v}, {1'b1, 8'h00});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule